// File: doc/BRIEF.md
# Differential Key-Byte Candidate Filter

This block narrows the last-round key of a 128-bit block cipher after a fault-injection experiment. It is given two ciphertexts for the same plaintext and key, one computed normally and one computed with a fault injected before the eighth round. It then lists every guess for the four last-round key bytes linked to output column 0 that fits the fault model.

For one guessed key byte K and a pair of ciphertext bytes (g, f) at the same position, the block forms the difference d = ISB(g xor K) xor ISB(f xor K), where ISB is the inverse substitution box. Four such differences a0..a3 exist, one for each row of the column. Two fault models are supported:

- **Single-diagonal model:** a fault in one diagonal forces fixed GF(2^8) ratios between the four differences.
- **Two-diagonal model:** a fault spread over two diagonals leaves two linear equations that the four differences must satisfy.

Every key quadruple that satisfies the selected model is sent out as one word with a one-cycle strobe. A done pulse marks the end of the list. An exhaustive search over the surviving quadruples is left to software.

The search works by value, not by brute force over all key guesses. First, one pass over all 256 byte values indexes, for each remaining key byte, which guesses give which difference. The controller then walks the reference key byte K13 (or the pair K13, K31). For each step it computes the differences the other bytes must reach and reads straight out of the index the lists of key bytes that reach them.

Top module: `dfa_cand_filter`

## Requirements
- R1: While reset is asserted, and after reset until a start, cand_valid and done are low.
- R2: Byte n (1..16, row-major) of a 128-bit ciphertext occupies bits [135-8n : 128-8n]. The differences a0, a1, a2, a3 use bytes 1, 8, 11 and 14 with key bytes K00, K13, K22 and K31 respectively. All other ciphertext bytes have no effect on the output. A candidate word is {K00, K13, K22, K31}, with K00 in bits 31:24.
- R3: With mode = 0 (single diagonal), every candidate satisfies a0 = 2·a1, a2 = a1 and a3 = 3·a1 in GF(2^8), using the reduction polynomial 0x11B.
- R4: With mode = 0, every quadruple that satisfies the R3 relations is emitted exactly once.
- R5: With mode = 1 (two diagonals), every candidate satisfies a0 = a1 xor a3 and 2·a1 xor 3·a3 = 7·a2. Every quadruple that satisfies both is emitted exactly once.
- R6: Within a run, the K13 field never decreases in mode 0, and the 16-bit value {K13, K31} never decreases in mode 1.
- R7: After the last candidate, or after a search with no survivors, done is high for exactly one cycle. Neither done nor cand_valid rises again until the next start.
- R8: A start pulse while a search is running is ignored.
- R9: The mode and both ciphertexts are captured on the start cycle. Later changes to them do not alter the current run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when the block is idle |
| mode | input | 1 | 0: single-diagonal relations, 1: two-diagonal relations |
| ct_good | input | 128 | Fault-free ciphertext |
| ct_bad | input | 128 | Faulty ciphertext |
| cand_valid | output | 1 | One-cycle strobe for each surviving candidate |
| cand_key | output | 32 | Candidate {K00, K13, K22, K31} |
| done | output | 1 | One-cycle pulse when the enumeration ends |

## Verification
The hardest situation to reach from the ports is a disturbance during a search. This means a second start pulse, together with changed ciphertexts and mode, arriving while the index is still being built. The bench drives exactly that a few cycles into a run. It then requires the full candidate list of the original inputs and a single done pulse.

Another rare path is the empty search. In it, one difference can only be zero, so no guess ever survives and the walk must still terminate. The bench reaches it by making byte 8 identical in both ciphertexts.

The two-diagonal mode is exercised on a random pair. The candidate stream, around 2^16 words, is compared against counts built from the bench's own difference histograms.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NKEY   = 1 << BYTE_W;
  localparam int unsigned NBYTE  = 16;
  localparam int unsigned BLK_W  = NBYTE * BYTE_W;
  localparam int unsigned CAND_W = 4 * BYTE_W;
  localparam int unsigned OUT_W  = 2 * BYTE_W;
  localparam int unsigned NTBL   = 3;

  // Row-major byte numbers feeding rows 0..3 of column 0 after the last row rotation
  localparam int unsigned POS_R0 = 1;
  localparam int unsigned POS_R1 = 8;
  localparam int unsigned POS_R2 = 11;
  localparam int unsigned POS_R3 = 14;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BUILD = 3'd1,
    ST_SEEK  = 3'd2,
    ST_EMIT  = 3'd3,
    ST_DONE  = 3'd4
  } fsm_t;

  function automatic byte_t gf_x2(byte_t v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_x3(byte_t v);
    return gf_x2(v) ^ v;
  endfunction

  function automatic byte_t gf_x7(byte_t v);
    return gf_x2(gf_x2(v)) ^ gf_x2(v) ^ v;
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // x^254 gives the field inverse (and maps 0 to 0)
  function automatic byte_t gf_inv(byte_t x);
    byte_t r;
    byte_t p;
    r = 8'h01;
    p = x;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t inv_sbox(byte_t y);
    byte_t t;
    t = {y[6:0], y[7]} ^ {y[4:0], y[7:5]} ^ {y[1:0], y[7:2]} ^ 8'h05;
    return gf_inv(t);
  endfunction

  function automatic byte_t blk_byte(logic [BLK_W-1:0] blk, int unsigned n);
    return blk[BLK_W - BYTE_W*n +: BYTE_W];
  endfunction

endpackage

// File: rtl/dfa_isb_diff.sv
module dfa_isb_diff
  import dfa_pkg::*;
#(
  parameter int unsigned POS = 1
) (
  input  logic [BLK_W-1:0] ct_a,
  input  logic [BLK_W-1:0] ct_b,
  input  byte_t            key,
  output byte_t            diff
);

  byte_t byte_a;
  byte_t byte_b;

  always_comb begin
    byte_a = blk_byte(ct_a, POS);
    byte_b = blk_byte(ct_b, POS);
    diff   = inv_sbox(byte_a ^ key) ^ inv_sbox(byte_b ^ key);
  end

endmodule

// File: rtl/dfa_val_index.sv
module dfa_val_index
  import dfa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  wr_en,
  input  byte_t wr_key,
  input  byte_t wr_val,
  input  byte_t q_val,
  output logic  q_hit,
  output byte_t q_head,
  input  byte_t ptr,
  output logic  nxt_vld,
  output byte_t nxt_key
);

  logic [NKEY-1:0] hv_q;
  logic [NKEY-1:0] hv_d;
  byte_t           head_mem [NKEY];
  logic [BYTE_W:0] link_mem [NKEY];

  always_comb begin
    hv_d = hv_q;
    if (clr) begin
      hv_d = '0;
    end else if (wr_en) begin
      hv_d[wr_val] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_q <= '0;
    else        hv_q <= hv_d;
  end

  // push-front: new key becomes list head, old head becomes its successor
  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      head_mem[wr_val] <= wr_key;
      link_mem[wr_key] <= {hv_q[wr_val], head_mem[wr_val]};
    end
  end

  assign q_hit             = hv_q[q_val];
  assign q_head            = head_mem[q_val];
  assign {nxt_vld, nxt_key} = link_mem[ptr];

  // R4: a value just indexed is found by a lookup of that value
  a_r4_hit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> ((q_val != $past(wr_val)) || q_hit));

endmodule

// File: rtl/dfa_cand_filter.sv
module dfa_cand_filter
  import dfa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode,
  input  logic [BLK_W-1:0]   ct_good,
  input  logic [BLK_W-1:0]   ct_bad,
  output logic               cand_valid,
  output logic [CAND_W-1:0]  cand_key,
  output logic               done
);

  fsm_t             st_q, st_d;
  byte_t            kcnt_q, kcnt_d;
  logic [OUT_W-1:0] outer_q, outer_d;
  logic             mode_q, mode_d;
  logic [BLK_W-1:0] ctg_q, ctg_d, ctb_q, ctb_d;
  byte_t            ptr_q [NTBL];
  byte_t            ptr_d [NTBL];

  byte_t d_bld [NTBL];
  byte_t wval  [NTBL];
  byte_t tgt   [NTBL];
  byte_t hd    [NTBL];
  byte_t nk    [NTBL];
  logic  hit   [NTBL];
  logic  nv    [NTBL];

  logic             tbl_clr, tbl_wr;
  byte_t            k13, k31w, a1, a3;
  logic [OUT_W-1:0] last_outer;
  logic             all_hit, wrap_outer;

  // ---------------- build side: one difference unit per indexed byte
  localparam int unsigned BLD_POS [NTBL] = '{POS_R0, POS_R2, POS_R3};

  for (genvar g = 0; g < NTBL; g++) begin : g_tbl
    dfa_isb_diff #(.POS(BLD_POS[g])) u_bdiff (
      .ct_a (ctg_q),
      .ct_b (ctb_q),
      .key  (kcnt_q),
      .diff (d_bld[g])
    );

    dfa_val_index u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tbl_clr),
      .wr_en   (tbl_wr),
      .wr_key  (kcnt_q),
      .wr_val  (wval[g]),
      .q_val   (tgt[g]),
      .q_hit   (hit[g]),
      .q_head  (hd[g]),
      .ptr     (ptr_q[g]),
      .nxt_vld (nv[g]),
      .nxt_key (nk[g])
    );
  end

  // ---------------- walk side: reference differences
  assign k13  = mode_q ? outer_q[OUT_W-1:BYTE_W] : outer_q[BYTE_W-1:0];
  assign k31w = outer_q[BYTE_W-1:0];

  dfa_isb_diff #(.POS(POS_R1)) u_diff_r1 (
    .ct_a (ctg_q),
    .ct_b (ctb_q),
    .key  (k13),
    .diff (a1)
  );

  dfa_isb_diff #(.POS(POS_R3)) u_diff_r3 (
    .ct_a (ctg_q),
    .ct_b (ctb_q),
    .key  (k31w),
    .diff (a3)
  );

  // index keys and targets: the two-diagonal mode indexes row 2 by 7*a2
  always_comb begin
    wval[0] = d_bld[0];
    wval[1] = mode_q ? gf_x7(d_bld[1]) : d_bld[1];
    wval[2] = d_bld[2];
    tgt[0]  = mode_q ? (a1 ^ a3) : gf_x2(a1);
    tgt[1]  = mode_q ? (gf_x2(a1) ^ gf_x3(a3)) : a1;
    tgt[2]  = gf_x3(a1);
  end

  // ---------------- next-state logic
  always_comb begin
    st_d       = st_q;
    kcnt_d     = kcnt_q;
    outer_d    = outer_q;
    mode_d     = mode_q;
    ctg_d      = ctg_q;
    ctb_d      = ctb_q;
    ptr_d      = ptr_q;
    tbl_clr    = 1'b0;
    tbl_wr     = 1'b0;
    wrap_outer = 1'b0;
    last_outer = mode_q ? {OUT_W{1'b1}} : {{(OUT_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    all_hit    = hit[0] && hit[1] && (mode_q || hit[2]);

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_BUILD;
          kcnt_d  = '0;
          outer_d = '0;
          mode_d  = mode;
          ctg_d   = ct_good;
          ctb_d   = ct_bad;
          tbl_clr = 1'b1;
        end
      end
      ST_BUILD: begin
        tbl_wr = 1'b1;
        kcnt_d = kcnt_q + 1'b1;
        if (kcnt_q == {BYTE_W{1'b1}}) st_d = ST_SEEK;
      end
      ST_SEEK: begin
        if (all_hit) begin
          for (int g = 0; g < NTBL; g++) ptr_d[g] = hd[g];
          st_d = ST_EMIT;
        end else begin
          wrap_outer = 1'b1;
        end
      end
      ST_EMIT: begin
        if (!mode_q && nv[2]) begin
          ptr_d[2] = nk[2];
        end else begin
          ptr_d[2] = hd[2];
          if (nv[1]) begin
            ptr_d[1] = nk[1];
          end else begin
            ptr_d[1] = hd[1];
            if (nv[0]) ptr_d[0] = nk[0];
            else       wrap_outer = 1'b1;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    if (wrap_outer) begin
      if (outer_q == last_outer) begin
        st_d = ST_DONE;
      end else begin
        outer_d = outer_q + 1'b1;
        st_d    = ST_SEEK;
      end
    end
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kcnt_q  <= '0;
      outer_q <= '0;
      mode_q  <= 1'b0;
      ctg_q   <= '0;
      ctb_q   <= '0;
      for (int g = 0; g < NTBL; g++) ptr_q[g] <= '0;
    end else begin
      st_q    <= st_d;
      kcnt_q  <= kcnt_d;
      outer_q <= outer_d;
      mode_q  <= mode_d;
      ctg_q   <= ctg_d;
      ctb_q   <= ctb_d;
      for (int g = 0; g < NTBL; g++) ptr_q[g] <= ptr_d[g];
    end
  end

  assign cand_valid = (st_q == ST_EMIT);
  assign done       = (st_q == ST_DONE);
  assign cand_key   = {ptr_q[0], k13, ptr_q[1], (mode_q ? outer_q[BYTE_W-1:0] : ptr_q[2])};

  // ---------------- assertions
  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: reference byte never decreases inside a burst (single-diagonal)
  a_r6_order_m0: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && $past(cand_valid) && !mode_q) |->
      (cand_key[23:16] >= $past(cand_key[23:16])));

  // R6: reference pair never decreases inside a burst (two-diagonal)
  a_r6_order_m1: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && $past(cand_valid) && mode_q) |->
      ({cand_key[23:16], cand_key[7:0]} >= $past({cand_key[23:16], cand_key[7:0]})));

  // R3: a candidate is only shown while its target values are present in the index
  a_r3_emit_has_hits: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (hit[0] && hit[1]));

  // R8: a start during the walk does not restart the index build
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == ST_EMIT) |=> (st_q != ST_BUILD));

endmodule

// File: tb/dfa_cand_filter_tb.sv
module dfa_cand_filter_tb;

  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 190000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [127:0] ct_good = '0;
  logic [127:0] ct_bad = '0;
  logic         cand_valid;
  logic [31:0]  cand_key;
  logic         done;

  dfa_cand_filter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .ct_good    (ct_good),
    .ct_bad     (ct_bad),
    .cand_valid (cand_valid),
    .cand_key   (cand_key),
    .done       (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit wd_hit = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG_CYC) wd_hit = 1'b1;
  end

  logic [7:0] isb_t [256];
  logic [7:0] dt [4][256];
  int unsigned row_pos [4] = '{1, 8, 11, 14};

  function automatic logic [7:0] m2(logic [7:0] v);
    return v[7] ? ((v << 1) ^ 8'h1b) : (v << 1);
  endfunction
  function automatic logic [7:0] m3(logic [7:0] v);
    return m2(v) ^ v;
  endfunction
  function automatic logic [7:0] m7(logic [7:0] v);
    return m2(m2(v)) ^ m3(v);
  endfunction
  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = m2(x);
    end
    return r;
  endfunction
  function automatic logic [7:0] rl(logic [7:0] v, int s);
    return (v << s) | (v >> (8 - s));
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv = 0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (gm(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      s = iv ^ rl(iv, 1) ^ rl(iv, 2) ^ rl(iv, 3) ^ rl(iv, 4) ^ 8'h63;
      isb_t[s] = 8'(x);
    end
  endtask

  function automatic logic [7:0] gb(logic [127:0] c, int unsigned n);
    return c[128 - 8*n +: 8];
  endfunction

  task automatic prep(logic [127:0] g, logic [127:0] b);
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 256; k++)
        dt[r][k] = isb_t[gb(g, row_pos[r]) ^ 8'(k)] ^ isb_t[gb(b, row_pos[r]) ^ 8'(k)];
  endtask

  function automatic longint ref_count(bit m);
    int h0 [256];
    int h2 [256];
    int h3 [256];
    longint tot = 0;
    for (int v = 0; v < 256; v++) begin h0[v] = 0; h2[v] = 0; h3[v] = 0; end
    for (int k = 0; k < 256; k++) begin
      h0[dt[0][k]]++;
      if (m) h2[m7(dt[2][k])]++; else h2[dt[2][k]]++;
      h3[dt[3][k]]++;
    end
    for (int k13 = 0; k13 < 256; k13++) begin
      logic [7:0] a1 = dt[1][k13];
      if (!m) begin
        tot += longint'(h0[m2(a1)]) * h2[a1] * h3[m3(a1)];
      end else begin
        for (int k31 = 0; k31 < 256; k31++) begin
          logic [7:0] a3 = dt[3][k31];
          tot += longint'(h0[a1 ^ a3]) * h2[m2(a1) ^ m3(a3)];
        end
      end
    end
    return tot;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one search and checks the whole stream
  task automatic run(bit m, logic [127:0] g, logic [127:0] b, bit disturb, string tag);
    bit     seen [int unsigned];
    longint ncand = 0;
    longint exp;
    int     nrel = 0, ndup = 0, nord = 0, ndone = 0, npost = 0, steps = 0;
    logic [15:0] last_ord = 0;
    prep(g, b);
    exp = ref_count(m);
    @(negedge clk);
    mode = m; ct_good = g; ct_bad = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!wd_hit) begin
      @(negedge clk);
      steps++;
      if (disturb && steps == 5) begin
        start = 1'b1; mode = ~m; ct_good = ~g; ct_bad = g;
      end
      if (disturb && steps == 6) start = 1'b0;
      if (disturb && steps == 400) start = 1'b1;
      if (disturb && steps == 401) start = 1'b0;
      if (cand_valid) begin
        logic [7:0] k0 = cand_key[31:24], k1 = cand_key[23:16];
        logic [7:0] k2 = cand_key[15:8],  k3 = cand_key[7:0];
        logic [7:0] a0 = dt[0][k0], a1 = dt[1][k1], a2 = dt[2][k2], a3 = dt[3][k3];
        logic [15:0] ok = m ? {k1, k3} : {8'h00, k1};
        if (!m) begin
          if (!(a0 == m2(a1) && a2 == a1 && a3 == m3(a1))) nrel++;
        end else begin
          if (!((a1 ^ a3) == a0 && (m2(a1) ^ m3(a3)) == m7(a2))) nrel++;
        end
        if (seen.exists(cand_key)) ndup++;
        seen[cand_key] = 1'b1;
        if (ncand != 0 && ok < last_ord) nord++;
        last_ord = ok;
        ncand++;
      end
      if (done) begin
        ndone++;
        break;
      end
    end
    repeat (4) begin
      @(negedge clk);
      if (done || cand_valid) npost++;
    end
    if (!m) begin
      chk(nrel == 0, {tag, " R3 relations"}, nrel, 0);
      chk(ncand == exp, {tag, " R4 count"}, ncand, exp);
      chk(ndup == 0, {tag, " R4 duplicates"}, ndup, 0);
    end else begin
      chk(nrel == 0, {tag, " R5 relations"}, nrel, 0);
      chk(ncand == exp, {tag, " R5 count"}, ncand, exp);
      chk(ndup == 0, {tag, " R5 duplicates"}, ndup, 0);
    end
    chk(nord == 0, {tag, " R6 order"}, nord, 0);
    chk(ndone == 1, {tag, " R7 done pulse"}, ndone, 1);
    chk(npost == 0, {tag, " R7 quiet after done"}, npost, 0);
    if (disturb) chk(ncand == exp && ndone == 1, {tag, " R8 R9 disturbed run"}, ncand, exp);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] g1, b1, g2, b2, g3, b3, gd, bd;
    void'($urandom(32'h1F2E3D4C));
    build_sbox();

    repeat (3) @(negedge clk);
    chk(!cand_valid && !done, "R1 in reset", {cand_valid, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cand_valid && !done, "R1 idle after reset", {cand_valid, done}, 0);

    g1 = rnd128(); b1 = rnd128();
    run(1'b0, g1, b1, 1'b0, "m0 random A");

    // R2: bytes outside positions 1,8,11,14 are ignored
    gd = rnd128(); bd = rnd128();
    for (int r = 0; r < 4; r++) begin
      gd[128 - 8*row_pos[r] +: 8] = gb(g1, row_pos[r]);
      bd[128 - 8*row_pos[r] +: 8] = gb(b1, row_pos[r]);
    end
    run(1'b0, gd, bd, 1'b0, "R2 other bytes");

    g2 = rnd128(); b2 = rnd128();
    run(1'b0, g2, b2, 1'b1, "m0 disturbed");

    // R7 corner: byte 8 equal in both ciphertexts, other bytes differ -> no survivor
    g3 = rnd128(); b3 = ~g3;
    b3[128 - 8*8 +: 8] = gb(g3, 8);
    prep(g3, b3);
    chk(ref_count(1'b0) == 0, "R7 empty reference", ref_count(1'b0), 0);
    run(1'b0, g3, b3, 1'b0, "R7 empty search");

    // directed: same unit difference at all four positions
    gd = '0; bd = '0;
    for (int r = 0; r < 4; r++) bd[128 - 8*row_pos[r] +: 8] = 8'h01;
    run(1'b0, gd, bd, 1'b0, "m0 directed");

    g1 = rnd128(); b1 = rnd128();
    run(1'b1, g1, b1, 1'b0, "m1 random");

    chk(!wd_hit, "watchdog", cyc, WATCHDOG_CYC);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule